// File: doc/BRIEF.md
# BT.656 Active-Video Extractor

This block sits on an incoming ITU-R 656 video byte stream, 8 or 10 bits per sample, and forwards only the samples that belong to active picture lines. It recognises the embedded timing-reference codes in the stream. From each code's status word it reads the field, vertical-blanking and horizontal flags, and it uses them to gate the data. Everything else is discarded: the codes, horizontal blanking between end-of-active and start-of-active, and vertical-blanking lines.

Forwarding begins only after the block has locked onto the start of field 1. From then on it counts the active lines it passes through across the frame, both fields included. When the programmed count is reached it goes quiet until the next start of field 1. Each forwarded sample carries a start-of-line marker on the first sample of a line and a start-of-frame marker on the first sample after a field-1 start. This lets a downstream writer build a frame without parsing the video stream again.

Top module: `vid_actv_extract`

## Requirements
- R1: While reset is asserted and after its release, out_valid, out_sol and out_sof are 0 until the block has locked and an active sample arrives.
- R2: A timing reference is four accepted bytes: key 0xFF, key 0x00, key 0x00, then a status word. The key is in_data[7:0] when wide_mode=0 and in_data[9:2] when wide_mode=1. In the status key, bit 6 is F, bit 5 is V and bit 4 is H. H=0 marks start of active video (SAV) and H=1 marks end of active video (EAV).
- R3: No sample is forwarded before the first field-1 start since reset.
- R4: A field-1 start is an SAV with F=0 and V=0 when the most recent earlier V=1 code has not been followed by any SAV with V=0.
- R5: Samples between an EAV and the next SAV are not forwarded.
- R6: Samples that follow an SAV with V=1 (vertical blanking) are not forwarded.
- R7: The bytes of a timing reference are never forwarded.
- R8: The first forwarded sample after a counted SAV has out_sol=1. The first forwarded sample after a field-1 start also has out_sof=1. All other forwarded samples have both markers at 0.
- R9: A forwarded sample accepted at one clock edge appears on out_data with out_valid=1 after that same edge. In 8-bit mode out_data[9:8] is 0 and out_data[7:0] equals in_data[7:0]. In 10-bit mode out_data equals in_data.
- R10: After a field-1 start, at most lines_per_frame SAVs with V=0, counting the start itself, open a line across both fields. Later lines are dropped until the next field-1 start. A count of 0 forwards nothing.
- R11: A cycle with in_valid=0 neither forwards data nor advances the timing-reference detection, whatever in_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | DATA_W | Input video byte (10 bits by default) |
| wide_mode | input | 1 | 1: 10-bit samples, 0: 8-bit samples in the low bits |
| lines_per_frame | input | LINE_W | Active lines forwarded per frame |
| out_valid | output | 1 | Forwarded sample qualifier |
| out_data | output | DATA_W | Forwarded active-video sample |
| out_sol | output | 1 | First sample of an active line |
| out_sof | output | 1 | First sample of a frame |

## Verification
The checker watches the cycle-level rules on every clock. No output appears before a frame marker has been seen. Markers never appear without valid data. A forwarded sample matches the input one cycle earlier, and no forwarded sample carries the all-ones key. A stalled input produces no output, and the line markers since the last frame marker never exceed the programmed count. Whether a particular sample should have been forwarded depends on the flags of codes seen many lines earlier, so only the bench's scenarios can show it. Those scenarios also cover the exact lock condition, blanking removal, counting across fields, relock, 10-bit passthrough and stalls inside a code, each compared sample by sample against a stream built from the requirements.

// File: rtl/vae_pkg.sv
package vae_pkg;

   localparam int unsigned KEY_W     = 8;
   localparam logic [7:0]  KEY_ONES  = 8'hFF;
   localparam logic [7:0]  KEY_ZERO  = 8'h00;
   localparam int unsigned F_POS     = 6;
   localparam int unsigned V_POS     = 5;
   localparam int unsigned H_POS     = 4;

   typedef enum logic [1:0] {
      TRS_IDLE = 2'd0,
      TRS_ONES = 2'd1,
      TRS_Z1   = 2'd2,
      TRS_Z2   = 2'd3
   } trs_state_e;

   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } trs_flags_t;

endpackage

// File: rtl/vae_key_select.sv
module vae_key_select #(
   parameter int unsigned DATA_W = 10
) (
   input  logic [DATA_W-1:0] in_data,
   input  logic              wide_mode,
   output logic [7:0]        key
);
   generate
      if (DATA_W > 8) begin : g_wide
         assign key = wide_mode ? in_data[DATA_W-1 -: 8] : in_data[7:0];
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide_mode;
         assign key = in_data[7:0];
      end
   endgenerate
endmodule

// File: rtl/vae_trs_detect.sv
module vae_trs_detect
   import vae_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] key,
   output logic       det_idle,
   output logic       code_stb,
   output trs_flags_t flags
);
   trs_state_e st_q, st_d;
   logic       is_ones, is_zero;

   assign is_ones = (key == KEY_ONES);
   assign is_zero = (key == KEY_ZERO);

   always_comb begin
      st_d = st_q;
      if (in_valid) begin
         case (st_q)
            TRS_IDLE: st_d = is_ones ? TRS_ONES : TRS_IDLE;
            TRS_ONES: st_d = is_zero ? TRS_Z1 : (is_ones ? TRS_ONES : TRS_IDLE);
            TRS_Z1:   st_d = is_zero ? TRS_Z2 : (is_ones ? TRS_ONES : TRS_IDLE);
            TRS_Z2:   st_d = TRS_IDLE;
            default:  st_d = TRS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= TRS_IDLE;
      else        st_q <= st_d;
   end

   assign det_idle = (st_q == TRS_IDLE);
   assign code_stb = in_valid && (st_q == TRS_Z2);
   assign flags.f  = key[F_POS];
   assign flags.v  = key[V_POS];
   assign flags.h  = key[H_POS];
endmodule

// File: rtl/vae_frame_ctrl.sv
module vae_frame_ctrl
   import vae_pkg::*;
#(
   parameter int unsigned LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              code_stb,
   input  trs_flags_t        flags,
   input  logic [LINE_W-1:0] lines_per_frame,
   input  logic              fwd,
   output logic              gate_open,
   output logic              sol_pend,
   output logic              sof_pend
);
   logic              locked_q, vb_seen_q, active_q;
   logic [LINE_W-1:0] line_cnt_q;
   logic              sav_act, f1_start, lines_nz, room_left;

   assign sav_act   = !flags.h && !flags.v;
   assign f1_start  = sav_act && !flags.f && vb_seen_q;
   assign lines_nz  = (lines_per_frame != '0);
   assign room_left = (line_cnt_q < lines_per_frame);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q   <= 1'b0;
         vb_seen_q  <= 1'b0;
         active_q   <= 1'b0;
         line_cnt_q <= '0;
         sol_pend   <= 1'b0;
         sof_pend   <= 1'b0;
      end else begin
         if (fwd) begin
            sol_pend <= 1'b0;
            sof_pend <= 1'b0;
         end
         if (code_stb) begin
            if (flags.v)       vb_seen_q <= 1'b1;
            else if (!flags.h) vb_seen_q <= 1'b0;
            if (f1_start) begin
               locked_q   <= 1'b1;
               active_q   <= lines_nz;
               line_cnt_q <= lines_nz ? LINE_W'(1) : '0;
               sol_pend   <= lines_nz;
               sof_pend   <= lines_nz;
            end else if (sav_act && locked_q && room_left) begin
               active_q   <= 1'b1;
               line_cnt_q <= line_cnt_q + LINE_W'(1);
               sol_pend   <= 1'b1;
            end else begin
               active_q   <= 1'b0;
               sol_pend   <= 1'b0;
            end
         end
      end
   end

   assign gate_open = active_q && locked_q;
endmodule

// File: rtl/vae_out_stage.sv
module vae_out_stage #(
   parameter int unsigned DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd,
   input  logic              wide_mode,
   input  logic [DATA_W-1:0] in_data,
   input  logic              sol_pend,
   input  logic              sof_pend,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sol,
   output logic              out_sof
);
   logic [DATA_W-1:0] data_sel;

   generate
      if (DATA_W > 8) begin : g_wide
         assign data_sel = wide_mode ? in_data
                                     : {{(DATA_W-8){1'b0}}, in_data[7:0]};
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide_mode;
         assign data_sel = in_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sol   <= 1'b0;
         out_sof   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= fwd;
         out_sol   <= fwd && sol_pend;
         out_sof   <= fwd && sof_pend;
         if (fwd) out_data <= data_sel;
      end
   end
endmodule

// File: rtl/vid_actv_extract.sv
module vid_actv_extract
   import vae_pkg::*;
#(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              wide_mode,
   input  logic [LINE_W-1:0] lines_per_frame,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sol,
   output logic              out_sof
);
   generate
      if (!(DATA_W == 8 || DATA_W == 10)) begin : g_bad_data_w
         $error("vid_actv_extract: DATA_W must be 8 or 10");
      end
      if (LINE_W < 1 || LINE_W > 16) begin : g_bad_line_w
         $error("vid_actv_extract: LINE_W must be 1..16");
      end
   endgenerate

   logic [7:0] key;
   logic       det_idle, code_stb, gate_open, sol_pend, sof_pend, fwd;
   trs_flags_t flags;

   vae_key_select #(.DATA_W(DATA_W)) u_key (
      .in_data   (in_data),
      .wide_mode (wide_mode),
      .key       (key)
   );

   vae_trs_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .key      (key),
      .det_idle (det_idle),
      .code_stb (code_stb),
      .flags    (flags)
   );

   vae_frame_ctrl #(.LINE_W(LINE_W)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .code_stb        (code_stb),
      .flags           (flags),
      .lines_per_frame (lines_per_frame),
      .fwd             (fwd),
      .gate_open       (gate_open),
      .sol_pend        (sol_pend),
      .sof_pend        (sof_pend)
   );

   assign fwd = in_valid && det_idle && (key != KEY_ONES) && gate_open;

   vae_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .fwd       (fwd),
      .wide_mode (wide_mode),
      .in_data   (in_data),
      .sol_pend  (sol_pend),
      .sof_pend  (sof_pend),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_sol   (out_sol),
      .out_sof   (out_sof)
   );
endmodule

// File: rtl/vae_checker.sv
module vae_checker #(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned LINE_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              wide_mode,
   input logic [LINE_W-1:0] lines_per_frame,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_sol,
   input logic              out_sof
);
   logic [LINE_W:0] sol_cnt_q;
   logic            sof_seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sol_cnt_q  <= '0;
         sof_seen_q <= 1'b0;
      end else begin
         if (out_sof)      sol_cnt_q <= (LINE_W+1)'(1);
         else if (out_sol) sol_cnt_q <= sol_cnt_q + (LINE_W+1)'(1);
         if (out_sof)      sof_seen_q <= 1'b1;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sof_seen_q |-> !(out_sol && !out_sof)); // R1

   AST_NO_OUT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sof || sof_seen_q)); // R3

   AST_MARK_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sol || out_sof) |-> out_valid); // R8

   AST_SOF_IS_SOL: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_sol); // R8

   AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[7:0] == $past(in_data[7:0]))); // R9

   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R11

   AST_LINE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sol && !out_sof) |-> (sol_cnt_q < {1'b0, lines_per_frame})); // R10

   AST_ZERO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> (lines_per_frame != '0)); // R10

   generate
      if (DATA_W > 8) begin : g_wide_chk
         AST_NO_CODE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (($past(wide_mode) ? out_data[DATA_W-1 -: 8]
                                             : out_data[7:0]) != 8'hFF)); // R7
         AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !$past(wide_mode)) |-> (out_data[DATA_W-1:8] == '0)); // R9
      end else begin : g_narrow_chk
         logic unused_chk;
         assign unused_chk = wide_mode;
         AST_NO_CODE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_data[7:0] != 8'hFF)); // R7
      end
   endgenerate
endmodule

bind vid_actv_extract vae_checker #(.DATA_W(DATA_W), .LINE_W(LINE_W)) chk_i (.*);

// File: tb/vid_actv_extract_tb_top.sv
`timescale 1ns/1ps
module vid_actv_extract_tb_top;
   localparam int DATA_W = 10;
   localparam int LINE_W = 11;

   typedef struct packed {
      logic [9:0] d;
      logic       sol;
      logic       sof;
   } rec_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              wide_mode = 1'b0;
   logic [LINE_W-1:0] lines_per_frame = '0;
   logic              out_valid, out_sol, out_sof;
   logic [DATA_W-1:0] out_data;

   int   n_checks = 0;
   int   n_fail = 0;
   int   seq = 0;
   bit   stall = 1'b0;
   bit   done = 1'b0;
   rec_t exp_q[$];
   rec_t got_q[$];

   always #2 clk = ~clk;

   vid_actv_extract #(.DATA_W(DATA_W), .LINE_W(LINE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .wide_mode(wide_mode), .lines_per_frame(lines_per_frame),
      .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid) got_q.push_back('{d: out_data, sol: out_sol, sof: out_sof});
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [9:0] mk(input logic [7:0] k, input logic [1:0] lo);
      return wide_mode ? {k, lo} : {2'b10, k};
   endfunction

   function automatic logic [9:0] seen(input logic [7:0] k, input logic [1:0] lo);
      return wide_mode ? {k, lo} : {2'b00, k};
   endfunction

   task automatic send(input logic [9:0] v);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = v;
      if (stall) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = 10'h3FF;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = 10'h3FF;
      end
   endtask

   // R2: FF, 00, 00, status with F=bit6, V=bit5, H=bit4
   task automatic send_code(input logic f, input logic v, input logic h);
      logic [7:0] st;
      st = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
      send(mk(8'hFF, 2'b11));
      send(mk(8'h00, 2'b01));
      send(mk(8'h00, 2'b01));
      send(mk(st, 2'b00));
   endtask

   task automatic send_line(input logic f, input logic v, input int n_act,
                            input bit expect_out, input bit first_of_frame);
      send_code(f, v, 1'b1);
      for (int i = 0; i < 3; i++) send(mk(8'h80, 2'b10));
      send_code(f, v, 1'b0);
      for (int i = 0; i < n_act; i++) begin
         logic [7:0] k;
         logic [1:0] lo;
         k  = 8'(8'h10 + (seq % 200));
         lo = 2'(seq);
         seq++;
         send(mk(k, lo));
         if (expect_out)
            exp_q.push_back('{d: seen(k, lo), sol: (i == 0), sof: (i == 0) && first_of_frame});
      end
   endtask

   task automatic compare(input string tag);
      idle(4);
      chk({tag, " sample count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk($sformatf("%s sample %0d {data,sol,sof}", tag, i), 32'(got_q[i]), 32'(exp_q[i]));
      exp_q.delete();
      got_q.delete();
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_q.delete();
      got_q.delete();
      seq = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 out_valid in reset", out_valid, 0);
      chk("R1 out_sol in reset", out_sol, 0);
      chk("R1 out_sof in reset", out_sof, 0);
      rst_n = 1'b1;
      idle(3);
      chk("R1 out_valid after reset", out_valid, 0);
      chk("R1 out_sof after reset", out_sof, 0);
   endtask

   task automatic t_prelock();
      apply_reset();
      wide_mode = 1'b0; stall = 1'b0; lines_per_frame = 11'd4;
      send_line(0, 0, 3, 0, 0);
      send_line(1, 1, 3, 0, 0);
      send_line(1, 0, 3, 0, 0);
      send_line(0, 0, 3, 0, 0);
      compare("R3 R4 no lock without blanking just before");
   endtask

   task automatic t_lock();
      apply_reset();
      wide_mode = 1'b0; stall = 1'b0; lines_per_frame = 11'd8;
      send_line(0, 0, 3, 0, 0);
      send_line(0, 1, 3, 0, 0);
      send_line(0, 0, 4, 1, 1);
      send_line(0, 0, 4, 1, 0);
      send_line(0, 0, 2, 1, 0);
      compare("R4 R5 R6 R7 R8 R9 lock and gating");
   endtask

   task automatic t_limit();
      apply_reset();
      wide_mode = 1'b0; stall = 1'b0; lines_per_frame = 11'd3;
      send_line(0, 1, 2, 0, 0);
      send_line(0, 0, 3, 1, 1);
      send_line(0, 0, 3, 1, 0);
      send_line(1, 1, 2, 0, 0);
      send_line(1, 0, 3, 1, 0);
      send_line(1, 0, 3, 0, 0);
      send_line(0, 1, 2, 0, 0);
      send_line(0, 0, 3, 1, 1);
      compare("R10 line limit across fields and relock");
   endtask

   task automatic t_zero();
      apply_reset();
      wide_mode = 1'b0; stall = 1'b0; lines_per_frame = 11'd0;
      send_line(0, 1, 2, 0, 0);
      send_line(0, 0, 3, 0, 0);
      send_line(0, 0, 3, 0, 0);
      compare("R10 zero lines");
   endtask

   task automatic t_wide();
      apply_reset();
      wide_mode = 1'b1; stall = 1'b0; lines_per_frame = 11'd2;
      send_line(0, 1, 2, 0, 0);
      send_line(0, 0, 5, 1, 1);
      send_line(0, 0, 5, 1, 0);
      send_line(0, 0, 5, 0, 0);
      compare("R2 R9 10-bit mode");
   endtask

   task automatic t_stall();
      apply_reset();
      wide_mode = 1'b0; stall = 1'b1; lines_per_frame = 11'd2;
      send_line(0, 1, 1, 0, 0);
      send_line(0, 0, 3, 1, 1);
      send_line(0, 0, 3, 1, 0);
      stall = 1'b0;
      compare("R11 stalled input");
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      t_reset();
      t_prelock();
      t_lock();
      t_limit();
      t_zero();
      t_wide();
      t_stall();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule